// File: doc/BRIEF.md
# Systolic LIFO Chain

This block is a last-in first-out store spread over a row of identical cells, each linked only to its two neighbours. There is no central memory and no central counter. The first cell in the row is the only one that faces the outside. Every clock it takes exactly one operation: a push of a symbol, or a pop that returns the top symbol. The block serves one growing phase followed by one shrinking phase. The first pop turns it around. From then on it only drains.

Each cell holds two stored symbols and one hand-off register toward its right neighbour. When a cell is full, a push sends its oldest symbol one cell to the right. The first pop starts a turn-around wave that moves right one cell per clock. A cell reached by the wave moves its second symbol into its head slot. After that, its head slot refills every clock from the right neighbour's head slot, so the symbols flow left one cell per clock. Every symbol carries a valid bit and a bottom marker. Popped symbols also travel right along a history track, one cell per clock, and leave at the far end.

The top controller has two named states: `PH_GROW` after reset, and `PH_SHRINK`, entered on the first pop (transition: any pop while growing). Each cell's direction register has three states. `DIR_INC` is the reset state. It moves to `DIR_SWITCH` on the clock the wave reaches the cell: a pop while growing for the first cell, or the left neighbour being in `DIR_SWITCH` for the others. `DIR_SWITCH` always moves to `DIR_DEC` on the next clock. `DIR_DEC` is final until reset.

Top module: `sys_stack`

## Requirements
- R1: After reset, `empty` is 1, and `error`, `pop_valid` and `hist_valid` are 0.
- R2: A pop taken at a clock edge puts the most recently pushed symbol not yet popped on `pop_data`, with `pop_valid` high, right after that same edge. After a push edge, `pop_valid` is 0. This holds for any stack depth from 1 to 2×CELLS when the first pop arrives.
- R3: `empty` is 0 right after any push edge in the growing phase. It is 1 right after the edge that pops the last stored symbol.
- R4: The first symbol pushed after reset is marked as the bottom. `pop_bottom` is 1, together with `pop_valid`, exactly on the pop that returns it, and 0 on all other pops.
- R5: A pop while `empty` is 1 returns `pop_valid` = 0 and sets `error` right after that edge.
- R6: A push taken after the first pop sets `error` right after that edge.
- R7: Capacity is 2×CELLS symbols. The push that takes the stack beyond capacity sets `error` at the edge CELLS−1 clocks after the edge that took it. `error` is 0 before that edge.
- R8: A symbol popped at edge e appears on `hist_data`, with `hist_valid` = 1, right after edge e+CELLS−1. `hist_valid` is 0 while no pop lies at that distance.
- R9: Once set, `error` stays 1 until reset, whatever the following operations are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_push | input | 1 | Operation this clock: 1 = push, 0 = pop |
| push_data | input | SYM_W | Symbol to push |
| pop_data | output | SYM_W | Symbol returned by the last pop |
| pop_valid | output | 1 | The last operation was a pop that returned a symbol |
| pop_bottom | output | 1 | The returned symbol was the bottom entry |
| hist_data | output | SYM_W | Popped symbol leaving the far end of the history track |
| hist_valid | output | 1 | `hist_data` holds a popped symbol |
| empty | output | 1 | No symbol is stored |
| error | output | 1 | Sticky protocol or capacity violation |

## Verification
`pop_data`, `pop_valid`, `pop_bottom`, `empty` and the pop-side and late-push errors all update at the very edge that takes the operation. The overflow error reaches the port CELLS−1 edges after the offending push, and a popped symbol reaches the history output CELLS−1 edges after its pop. The bench applies one operation per clock and samples at the falling edge after each operation's rising edge. It compares the pop outputs and flags with that operation's expected values. History and overflow results are matched against the pop or push made CELLS−1 operations earlier.

// File: rtl/sstk_pkg.sv
package sstk_pkg;

    // Direction held by every cell of the chain.
    typedef enum logic [1:0] {
        DIR_INC    = 2'd0,
        DIR_SWITCH = 2'd1,
        DIR_DEC    = 2'd2
    } dir_e;

    // Phase seen by the controller at the head of the chain.
    typedef enum logic {
        PH_GROW   = 1'b0,
        PH_SHRINK = 1'b1
    } phase_e;

endpackage

// File: rtl/stk_cell.sv
// One cell of the chain. Symbol layout: [W+1] valid, [W] bottom marker, [W-1:0] data.
module stk_cell
    import sstk_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         arrive_i,   // turn-around wave reaches this cell now
    input  logic [W+1:0] feed_i,     // symbol handed over from the left
    input  logic [W+1:0] right_i,    // head slot of the right neighbour
    output dir_e         dir_o,
    output logic [W+1:0] head_o,
    output logic [W+1:0] xfer_o,     // hand-off register toward the right
    output logic         spill_o     // a stored symbol is pushed out of this cell
);

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_PUSH  = 2'd1,
        ACT_TURN  = 2'd2,
        ACT_DRAIN = 2'd3
    } act_e;

    dir_e         dir_q, dir_d;
    act_e         act;
    logic [W+1:0] slot0_q, slot1_q, hand_q;

    always_comb begin
        dir_d = dir_q;
        act   = ACT_HOLD;
        unique case (dir_q)
            DIR_INC: begin
                if (arrive_i) begin
                    dir_d = DIR_SWITCH;
                    act   = ACT_TURN;
                end else if (feed_i[W+1]) begin
                    act   = ACT_PUSH;
                end
            end
            DIR_SWITCH: begin
                dir_d = DIR_DEC;
                act   = ACT_DRAIN;
            end
            DIR_DEC: begin
                act   = ACT_DRAIN;
            end
            default: begin
                dir_d = DIR_INC;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= DIR_INC;
        end else begin
            dir_q <= dir_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot0_q <= '0;
            slot1_q <= '0;
            hand_q  <= '0;
        end else begin
            unique case (act)
                ACT_PUSH: begin
                    slot0_q <= feed_i;
                    slot1_q <= slot0_q;
                    hand_q  <= slot1_q;
                end
                ACT_TURN: begin
                    slot0_q <= slot1_q;
                    slot1_q <= '0;
                    hand_q  <= '0;
                end
                ACT_DRAIN: begin
                    slot0_q <= right_i;
                    slot1_q <= '0;
                    hand_q  <= '0;
                end
                default: begin
                    hand_q  <= '0;
                end
            endcase
        end
    end

    assign dir_o   = dir_q;
    assign head_o  = slot0_q;
    assign xfer_o  = hand_q;
    assign spill_o = (act == ACT_PUSH) && slot1_q[W+1];

endmodule

// File: rtl/stk_trail.sv
// History track: popped symbols march right one stage per clock.
module stk_trail #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_vld,
    input  logic [W-1:0] in_dat,
    output logic         out_vld,
    output logic [W-1:0] out_dat
);

    logic         vld_q [DEPTH];
    logic [W-1:0] dat_q [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
        logic         src_vld;
        logic [W-1:0] src_dat;
        if (k == 0) begin : g_first
            assign src_vld = in_vld;
            assign src_dat = in_dat;
        end else begin : g_next
            assign src_vld = vld_q[k-1];
            assign src_dat = dat_q[k-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q[k] <= 1'b0;
                dat_q[k] <= '0;
            end else begin
                vld_q[k] <= src_vld;
                dat_q[k] <= src_vld ? src_dat : '0;
            end
        end
    end

    assign out_vld = vld_q[DEPTH-1];
    assign out_dat = dat_q[DEPTH-1];

endmodule

// File: rtl/sys_stack.sv
module sys_stack
    import sstk_pkg::*;
#(
    parameter int SYM_W = 8,
    parameter int CELLS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_push,
    input  logic [SYM_W-1:0] push_data,
    output logic [SYM_W-1:0] pop_data,
    output logic             pop_valid,
    output logic             pop_bottom,
    output logic [SYM_W-1:0] hist_data,
    output logic             hist_valid,
    output logic             empty,
    output logic             error
);

    localparam int SW  = SYM_W + 2;
    localparam int VLD = SW - 1;
    localparam int BOT = SW - 2;

    phase_e        phase_q, phase_d;
    dir_e          dir   [CELLS];
    logic [SW-1:0] head  [CELLS];
    logic [SW-1:0] xfer  [CELLS];
    logic          spill [CELLS];

    logic pop_now, pop_hit, err_set;

    assign pop_now = !op_push;
    assign pop_hit = pop_now && head[0][VLD];

    for (genvar k = 0; k < CELLS; k++) begin : g_cell
        logic          arrive;
        logic [SW-1:0] feed, right;
        if (k == 0) begin : g_origin
            assign arrive = pop_now && (phase_q == PH_GROW);
            assign feed   = op_push ? {1'b1, ~head[0][VLD], push_data} : '0;
        end else begin : g_inner
            assign arrive = (dir[k-1] == DIR_SWITCH);
            assign feed   = xfer[k-1];
        end
        if (k == CELLS - 1) begin : g_end
            assign right = '0;
        end else begin : g_link
            assign right = head[k+1];
        end
        stk_cell #(.W(SYM_W)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .arrive_i (arrive),
            .feed_i   (feed),
            .right_i  (right),
            .dir_o    (dir[k]),
            .head_o   (head[k]),
            .xfer_o   (xfer[k]),
            .spill_o  (spill[k])
        );
    end

    stk_trail #(.W(SYM_W), .DEPTH(CELLS)) u_trail (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (pop_hit),
        .in_dat  (head[0][SYM_W-1:0]),
        .out_vld (hist_valid),
        .out_dat (hist_data)
    );

    // Controller phase
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_GROW:   if (pop_now) phase_d = PH_SHRINK;
            PH_SHRINK: phase_d = PH_SHRINK;
            default:   phase_d = PH_GROW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_GROW;
        end else begin
            phase_q <= phase_d;
        end
    end

    assign err_set = (pop_now && !head[0][VLD])
                   || (op_push && (phase_q == PH_SHRINK))
                   || spill[CELLS-1];

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pop_data   <= '0;
            pop_valid  <= 1'b0;
            pop_bottom <= 1'b0;
            error      <= 1'b0;
        end else begin
            pop_data   <= pop_hit ? head[0][SYM_W-1:0] : '0;
            pop_valid  <= pop_hit;
            pop_bottom <= pop_hit && head[0][BOT];
            error      <= error || err_set;
        end
    end

    assign empty = !head[0][VLD];

endmodule

// File: rtl/sys_stack_chk.sv
module sys_stack_chk
    import sstk_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   op_push,
    input logic   empty,
    input logic   error,
    input logic   pop_valid,
    input logic   pop_bottom,
    input phase_e phase
);

    // R2
    popv_after_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_valid |-> $past(!op_push));

    // R3
    push_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_push && phase == PH_GROW) |=> !empty);

    // R4
    bottom_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_bottom |-> (empty && pop_valid));

    // R5
    pop_empty_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_push && empty) |=> (error && !pop_valid));

    // R6
    late_push_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_push && phase == PH_SHRINK) |=> error);

    // R9
    error_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> error);

endmodule

bind sys_stack sys_stack_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_push    (op_push),
    .empty      (empty),
    .error      (error),
    .pop_valid  (pop_valid),
    .pop_bottom (pop_bottom),
    .phase      (phase_q)
);

// File: tb/sys_stack_tb.sv
`timescale 1ns/1ps
module sys_stack_tb;

    localparam int W     = 8;
    localparam int CELLS = 4;
    localparam int CAP   = 2 * CELLS;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_push = 1'b1;
    logic [W-1:0] push_data = '0;
    logic [W-1:0] pop_data, hist_data;
    logic         pop_valid, pop_bottom, hist_valid, empty, error;

    int n_chk = 0;
    int n_fail = 0;

    logic [W-1:0] mdl [0:31];
    int           sp;
    logic [W-1:0] popped [0:31];

    always #4 clk = ~clk;

    sys_stack #(.SYM_W(W), .CELLS(CELLS)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_push    (op_push),
        .push_data  (push_data),
        .pop_data   (pop_data),
        .pop_valid  (pop_valid),
        .pop_bottom (pop_bottom),
        .hist_data  (hist_data),
        .hist_valid (hist_valid),
        .empty      (empty),
        .error      (error)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic push, input logic [W-1:0] d);
        op_push   = push;
        push_data = d;
        @(negedge clk);
    endtask

    task automatic do_reset();
        op_push = 1'b1;
        push_data = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        sp = 0;
        check("R1 empty", empty, 1);
        check("R1 error", error, 0);
        check("R1 pop_valid", pop_valid, 0);
        check("R1 hist_valid", hist_valid, 0);
    endtask

    task automatic push_one(input logic [W-1:0] d);
        step(1'b1, d);
        mdl[sp] = d;
        sp++;
        check("R3 empty after push", empty, 0);
        check("R2 no pop_valid on push", pop_valid, 0);
    endtask

    task automatic pop_one(input int idx);
        step(1'b0, '0);
        sp--;
        popped[idx] = mdl[sp];
        check("R2 pop_valid", pop_valid, 1);
        check("R2 pop_data", pop_data, mdl[sp]);
        check("R4 pop_bottom", pop_bottom, (sp == 0));
        check("R3 empty after pop", empty, (sp == 0));
    endtask

    // Fill to capacity, drain fully, then one pop too many.
    task automatic t_full();
        do_reset();
        for (int i = 0; i < CAP; i++) push_one(W'(8'hA5 ^ (i * 37)));
        check("R7 no error at capacity", error, 0);
        for (int j = 0; j < CAP; j++) begin
            pop_one(j);
            check("R5 no error while stocked", error, 0);
            if (j >= CELLS - 1) begin
                check("R8 hist_valid", hist_valid, 1);
                check("R8 hist_data", hist_data, popped[j-CELLS+1]);
            end else begin
                check("R8 hist idle", hist_valid, 0);
            end
        end
        step(1'b0, '0);
        check("R5 pop_valid on empty pop", pop_valid, 0);
        check("R5 error on empty pop", error, 1);
        check("R8 hist tail", hist_data, popped[CAP-CELLS+1]);
        step(1'b1, 8'h11);
        check("R9 error sticky", error, 1);
        step(1'b0, '0);
        check("R9 error sticky", error, 1);
    endtask

    // Small stack: the wave runs mostly over empty cells.
    task automatic t_short();
        do_reset();
        push_one(8'h3C);
        push_one(8'hC3);
        push_one(8'h7E);
        for (int j = 0; j < 3; j++) pop_one(j);
        check("R5 no error before underflow", error, 0);
        step(1'b0, '0);
        check("R5 error on underflow", error, 1);
    endtask

    // Single symbol.
    task automatic t_single();
        do_reset();
        push_one(8'h42);
        pop_one(0);
        check("R4 single is bottom", pop_bottom, 1);
        check("R5 no error", error, 0);
    endtask

    // Turn mid-way, then push after the turn.
    task automatic t_turn();
        do_reset();
        for (int i = 0; i < 5; i++) push_one(W'(8'h20 + i * 3));
        pop_one(0);
        pop_one(1);
        check("R6 no error before late push", error, 0);
        step(1'b1, 8'hEE);
        check("R6 error on late push", error, 1);
    endtask

    // Overflow: push CAP+1 symbols and keep pushing.
    task automatic t_overflow();
        do_reset();
        for (int i = 1; i <= CAP + CELLS; i++) begin
            step(1'b1, W'(i));
            if (i == CAP + CELLS - 1) check("R7 error not yet", error, 0);
            if (i == CAP + CELLS)     check("R7 error raised", error, 1);
        end
    endtask

    // Pop as the very first operation.
    task automatic t_pop_first();
        do_reset();
        step(1'b0, '0);
        check("R5 first pop pop_valid", pop_valid, 0);
        check("R5 first pop error", error, 1);
        check("R3 still empty", empty, 1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        t_full();
        t_short();
        t_single();
        t_turn();
        t_overflow();
        t_pop_first();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule